// File: doc/BRIEF.md
# Masked BAR Address Translator

This block turns a narrow local bus address into a full 64-bit fabric address. It merges three sources: a base address register (BAR), a BAR mask, and an extended-address field. Each bit of a masked window is chosen separately. A set mask bit lets the local or extended address through. A clear mask bit keeps the BAR bit. Above the window sits a field that always comes from the BAR. Below the window, the low local bits pass straight through. The top byte of the result is always zero.

Software or a bus agent loads the source values first. It then writes a refresh register with its most significant bit set. One clock later the block presents the new address, together with a one-cycle valid strobe. The address then holds until the next armed refresh.

Bit numbers below count from the least significant bit, which is bit 0. Each input port carries only the address bits that can reach the result. The `barField` port carries address bits 55:20, so port bit k is address bit k+20. The `maskField` port carries address bits 40:20, so port bit k is address bit k+20. The `extField` port lands on address bits 40:27, so port bit k is address bit k+27.

Top module: `bar_xlate`

## Requirements
- R1: While reset is asserted, and after its release until the first armed refresh, `fabricAddr` is zero and `addrValid` is low.
- R2: A cycle with `refreshWr`=1 and `refreshArm`=1 loads a new address, and `addrValid` is high for exactly the following cycle.
- R3: A refresh write with `refreshArm`=0 is ignored. `addrValid` stays low and `fabricAddr` keeps its previous value.
- R4: Result bits 19:0 equal `localAddr[19:0]`, whatever the mask.
- R5: For result bits 26:20, a set mask bit selects the same-numbered `localAddr` bit.
- R6: For result bits 40:27, a set mask bit selects `extField[bit-27]`.
- R7: For result bits 40:20, a clear mask bit selects the BAR bit, which is `barField[bit-20]`.
- R8: Result bits 55:41 always equal `barField[35:21]`, whatever the mask.
- R9: Result bits 63:56 are always zero.
- R10: Between armed refreshes, `fabricAddr` does not change, even when the source inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refreshWr | input | 1 | Write strobe to the refresh register |
| refreshArm | input | 1 | Most significant bit of the refresh write data |
| barField | input | 36 | BAR bits, address bits 55:20 |
| maskField | input | 21 | BAR mask bits, address bits 40:20 |
| extField | input | 14 | Extended-address field, placed at bits 40:27 |
| localAddr | input | 27 | Low local bus address bits 26:0 |
| fabricAddr | output | 64 | Registered translated address |
| addrValid | output | 1 | One-cycle strobe after an armed refresh |

## Verification
The stimulus patterns are chosen so that a fault in one source shows up in a specific part of the result.

- **All zeros and all ones** show whether each field is driven at all. They also show whether the top byte stays empty.
- **BAR set, mask clear** lights the whole BAR span. Any bit wrongly taken from the local or extended inputs stands out.
- **BAR clear, mask set, local and extended ones** lights only the window and the pass-through field.
- **Alternating and irregular patterns** expose a swapped or off-by-one slice.

Directed cases check that an unarmed refresh is ignored. They also check that inputs changing while idle leave the output untouched. Finally, back-to-back armed refreshes must each produce their own strobe.

// File: rtl/bar_xlate_pkg.sv
package bar_xlate_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;
  } xlateStrobe_t;
endpackage

// File: rtl/bar_xlate_ctrl.sv
module bar_xlate_ctrl
  import bar_xlate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         refreshWr,
  input  logic         refreshArm,
  output xlateStrobe_t strobe,
  output logic         addrValid
);
  // only a write carrying a set top bit triggers a recompute
  always_comb strobe.load = refreshWr && refreshArm;

  always_ff @(posedge clk) begin
    if (!rstN) addrValid <= 1'b0;
    else       addrValid <= strobe.load;
  end
endmodule

// File: rtl/bar_xlate_datapath.sv
module bar_xlate_datapath
  import bar_xlate_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int PASS_W   = 20,
  parameter int LOCMSK_W = 7,
  parameter int EXT_W    = 14,
  parameter int BARHI_W  = 15,
  localparam int EXT_LSB   = PASS_W + LOCMSK_W,
  localparam int BARHI_LSB = EXT_LSB + EXT_W,
  localparam int ZERO_LSB  = BARHI_LSB + BARHI_W,
  localparam int BAR_W     = ZERO_LSB - PASS_W,
  localparam int MASK_W    = BARHI_LSB - PASS_W,
  localparam int LOCAL_W   = EXT_LSB
)(
  input  logic               clk,
  input  logic               rstN,
  input  xlateStrobe_t       strobe,
  input  logic [BAR_W-1:0]   barField,
  input  logic [MASK_W-1:0]  maskField,
  input  logic [EXT_W-1:0]   extField,
  input  logic [LOCAL_W-1:0] localAddr,
  output logic [ADDR_W-1:0]  fabricAddr
);
  logic [ADDR_W-1:0] merged;

  // per-bit source selection, picked by position
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i < PASS_W) begin : g_pass
      assign merged[i] = localAddr[i];
    end else if (i < EXT_LSB) begin : g_loc
      assign merged[i] = maskField[i-PASS_W] ? localAddr[i] : barField[i-PASS_W];
    end else if (i < BARHI_LSB) begin : g_ext
      assign merged[i] = maskField[i-PASS_W] ? extField[i-EXT_LSB] : barField[i-PASS_W];
    end else if (i < ZERO_LSB) begin : g_bar
      assign merged[i] = barField[i-PASS_W];
    end else begin : g_zero
      assign merged[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            fabricAddr <= '0;
    else if (strobe.load) fabricAddr <= merged;
  end
endmodule

// File: rtl/bar_xlate.sv
module bar_xlate
  import bar_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        refreshWr,
  input  logic        refreshArm,
  input  logic [35:0] barField,
  input  logic [20:0] maskField,
  input  logic [13:0] extField,
  input  logic [26:0] localAddr,
  output logic [63:0] fabricAddr,
  output logic        addrValid
);
  xlateStrobe_t strobe;

  bar_xlate_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .refreshWr  (refreshWr),
    .refreshArm (refreshArm),
    .strobe     (strobe),
    .addrValid  (addrValid)
  );

  bar_xlate_datapath #(
    .ADDR_W   (64),
    .PASS_W   (20),
    .LOCMSK_W (7),
    .EXT_W    (14),
    .BARHI_W  (15)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .barField   (barField),
    .maskField  (maskField),
    .extField   (extField),
    .localAddr  (localAddr),
    .fabricAddr (fabricAddr)
  );
endmodule

// File: rtl/bar_xlate_checker.sv
module bar_xlate_checker (
  input logic        clk,
  input logic        rstN,
  input logic        refreshWr,
  input logic        refreshArm,
  input logic [35:0] barField,
  input logic [26:0] localAddr,
  input logic [63:0] fabricAddr,
  input logic        addrValid
);
  a_r2_valid_follows_refresh: assert property (@(posedge clk) disable iff (!rstN)
    (refreshWr && refreshArm) |=> addrValid);

  a_r3_unarmed_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !(refreshWr && refreshArm) |=> !addrValid);

  a_r10_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !(refreshWr && refreshArm) |=> $stable(fabricAddr));

  a_r4_pass_field: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> fabricAddr[19:0] == $past(localAddr[19:0]));

  a_r8_bar_high: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> fabricAddr[55:41] == $past(barField[35:21]));

  a_r9_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    fabricAddr[63:56] == 8'h00);
endmodule

bind bar_xlate bar_xlate_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .refreshWr  (refreshWr),
  .refreshArm (refreshArm),
  .barField   (barField),
  .localAddr  (localAddr),
  .fabricAddr (fabricAddr),
  .addrValid  (addrValid)
);

// File: tb/tb_bar_xlate.sv
module tb_bar_xlate;
  logic        clk = 1'b0;
  logic        rstN;
  logic        refreshWr, refreshArm;
  logic [35:0] barField;
  logic [20:0] maskField;
  logic [13:0] extField;
  logic [26:0] localAddr;
  logic [63:0] fabricAddr;
  logic        addrValid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  bar_xlate dut (.*);

  typedef struct packed {
    logic [35:0] bar;
    logic [20:0] mask;
    logic [13:0] ext;
    logic [26:0] loc;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{36'h0,           21'h0,       14'h0,      27'h0},
    '{36'hF_FFFF_FFFF, 21'h1F_FFFF, 14'h3FFF,   27'h7FF_FFFF},
    '{36'hF_FFFF_FFFF, 21'h0,       14'h0,      27'h0},
    '{36'h0,           21'h1F_FFFF, 14'h3FFF,   27'h7FF_FFFF},
    '{36'hA_5A5A_5A5A, 21'h15_5555, 14'h2AAA,   27'h555_5555},
    '{36'h1_2345_6789, 21'h0F_0F0F, 14'h3C3C,   27'h6AB_CDEF}
  };

  // expected result, bit by bit, from R4..R9
  function automatic logic [63:0] model(vec_t v);
    logic [63:0] r = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < 20)      r[i] = v.loc[i];
      else if (i < 27) r[i] = v.mask[i-20] ? v.loc[i]     : v.bar[i-20];
      else if (i < 41) r[i] = v.mask[i-20] ? v.ext[i-27]  : v.bar[i-20];
      else if (i < 56) r[i] = v.bar[i-20];
      else             r[i] = 1'b0;
    end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setVec(vec_t v);
    barField = v.bar; maskField = v.mask; extField = v.ext; localAddr = v.loc;
  endtask

  // one refresh write, issued at a falling edge; returns at the next falling edge
  task automatic refresh(logic arm);
    refreshWr = 1'b1; refreshArm = arm;
    @(negedge clk);
    refreshWr = 1'b0; refreshArm = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=5000 cycles", cycles);
      finishRun();
    end
  end

  initial begin
    logic [63:0] held;
    rstN = 1'b0; refreshWr = 1'b0; refreshArm = 1'b0;
    setVec(VECS[1]);
    repeat (3) @(negedge clk);
    check("R1 reset addr", fabricAddr, 64'h0);
    check("R1 reset valid", {63'h0, addrValid}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset addr", fabricAddr, 64'h0);

    // table walk: covers R2, R4..R9
    for (int k = 0; k < NVEC; k++) begin
      setVec(VECS[k]);
      refresh(1'b1);
      check("R2 valid pulse", {63'h0, addrValid}, 64'h1);
      check("R4-R9 address", fabricAddr, model(VECS[k]));
      check("R9 top byte", {56'h0, fabricAddr[63:56]}, 64'h0);
      @(negedge clk);
      check("R2 single cycle", {63'h0, addrValid}, 64'h0);
    end

    // R3: unarmed write ignored
    held = fabricAddr;
    setVec(VECS[2]);
    refresh(1'b0);
    check("R3 no valid", {63'h0, addrValid}, 64'h0);
    check("R3 addr held", fabricAddr, held);

    // R10: inputs change with no refresh
    setVec(VECS[3]);
    repeat (3) @(negedge clk);
    check("R10 addr stable", fabricAddr, held);

    // R5/R6/R7 isolation: mask set only in the local window
    setVec('{36'h0, 21'h00_007F, 14'h3FFF, 27'h7F0_0000});
    refresh(1'b1);
    check("R5 local window", fabricAddr, 64'h0000_0000_07F0_0000);
    setVec('{36'h0, 21'h1F_FF80, 14'h2001, 27'h0});
    refresh(1'b1);
    check("R6 ext window", fabricAddr, 64'h0000_0100_0800_0000);
    setVec('{36'h0_001F_FFFF, 21'h0, 14'h3FFF, 27'h7F0_0000});
    refresh(1'b1);
    check("R7 bar window", fabricAddr, 64'h0000_01FF_FFF0_0000);

    // back-to-back armed refreshes
    setVec(VECS[4]);
    refreshWr = 1'b1; refreshArm = 1'b1;
    @(negedge clk);
    check("R2 first of pair", fabricAddr, model(VECS[4]));
    setVec(VECS[5]);
    @(negedge clk);
    refreshWr = 1'b0; refreshArm = 1'b0;
    check("R2 second of pair valid", {63'h0, addrValid}, 64'h1);
    check("R2 second of pair addr", fabricAddr, model(VECS[5]));

    // R1: reset mid-run clears state
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset clears", fabricAddr, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    finishRun();
  end
endmodule